// File: doc/BRIEF.md
# Flash Modify-Operation Sequencer

This block sits behind the host write port of an emulated flash memory and runs every operation that changes the array: erasing one block, erasing the whole chip, writing one word, setting one block's lock bit and clearing all lock bits. The host presents one decoded command per cycle on `cmd_valid`/`cmd_code`. The sequencer checks the modify-enable input `vpp_ok`, the write-protect input `wp_n` and the lock bit of the addressed block. It then either starts a timed operation or rejects the command by setting sticky error bits. The array holds `NUM_BLK` blocks of `WPB` words. The upper address bits pick the block and the lower bits pick the word. Reads on `rd_addr`/`rd_data` are combinational and available at all times.

An erase or a write can be suspended and later resumed. While an erase is suspended the host may write to other blocks. The status register is always visible on `status`. The open-drain status pin is modelled as `sts_pull`, where 1 means the pin is pulled low and 0 means it is released. In level mode the pin is pulled low while an operation runs. In one of three pulse modes it is pulled low for one cycle when an operation of the selected class completes.

The controller is one state machine with these states: IDLE, ERASE, WRITE, LOCK, ESUSP (erase suspended), WSUSP (write suspended) and ESWRITE (a write running while an erase is suspended). Its transitions are:
- IDLE to ERASE, WRITE or LOCK on an accepted command.
- ERASE, WRITE or LOCK back to IDLE when the operation completes.
- ERASE to ESUSP, and WRITE to WSUSP, on suspend.
- ESUSP to ERASE, and WSUSP to WRITE, on resume.
- ESUSP to ESWRITE on an accepted write, and ESWRITE back to ESUSP when that write completes.

Top module: `flash_seq_ctrl`

## Requirements
- R1: `cmd_code` encodings are: 1 erase block, 2 erase chip, 3 write, 4 set lock, 5 clear all locks, 6 suspend, 7 resume, 8 clear status, 9 configure pin. A block erase sets every word of the block chosen by the upper address bits to all ones, and leaves every other block unchanged.
- R2: A chip erase sets every word of every block to all ones.
- R3: A write stores the AND of the old word and `cmd_data`, so a write can only clear bits.
- R4: When `wp_n` is 0, an erase or write aimed at a locked block is rejected and the array is left unchanged. A rejected erase sets status bits 5 and 1; a rejected write sets bits 4 and 1. A chip erase is rejected if any block is locked. When `wp_n` is 1, lock bits do not block erase or write.
- R5: Set-lock and clear-locks are rejected when `wp_n` is 0, setting status bits 4 and 1, and the lock bits are left unchanged.
- R6: When `vpp_ok` is 0, every modify command is rejected. It sets status bit 3 plus bit 5 (erase) or bit 4 (write and lock commands).
- R7: A suspend during ERASE holds the erase: status bit 6 is set, bit 7 (ready) is 1, and the block keeps its data. While suspended, a write to another block runs and completes. A write to the block being erased, or any write while a chip erase is suspended, is rejected with bit 4. A resume finishes the erase.
- R8: A suspend during WRITE holds the write with status bit 2 set and bit 7 set. A resume completes the write.
- R9: In level mode (configure data 0), `sts_pull` is 1 exactly while status bit 7 is 0.
- R10: Configure data 1, 2 and 3 select one-cycle pulses on `sts_pull`. Mode 1 pulses when an erase completes, mode 2 when a word write completes, and mode 3 for both. A pulse starts in the cycle after completion. Mode 2 gives no pulse for an erase, and mode 1 gives none for a write.
- R11: A suspend that arrives in the final cycle of an operation is ignored. The operation completes and the state returns to ready with no suspend bit set.
- R12: Error bits 5, 4, 3 and 1 stay set until a clear-status command. Clear-status clears only those bits and leaves the suspend bits unchanged.
- R13: While `rst_n` is 0 the sequencer is idle and the pin is released. A running operation is abandoned with the array unchanged. On release, status reads 0x80 and the pin is in level mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset and deep power-down |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_code | input | 4 | Decoded command code |
| cmd_addr | input | AW | Target address (block in the upper bits) |
| cmd_data | input | DW | Write data, or pin mode in bits 1:0 |
| wp_n | input | 1 | Write protect; 0 makes lock bits effective |
| vpp_ok | input | 1 | Modify supply above its lockout level |
| rd_addr | input | AW | Array read address |
| rd_data | output | DW | Array read data |
| status | output | 8 | Status register: 7 ready, 6 erase suspended, 5 erase error, 4 write error, 3 supply error, 2 write suspended, 1 lock error |
| sts_pull | output | 1 | 1 pulls the open-drain status pin low |

## Verification
Completion and suspend can arrive in the same cycle: a suspend command can be accepted on the edge where the operation timer reaches its last count. The bench times a suspend to land on the final cycle of a write. It expects the write to finish with status 0x80 and the new data stored. It also sends a suspend one cycle earlier and expects the write-suspended state. A second overlap is an erase completing under pulse mode while the host's next command is already waiting. For this the bench counts the cycles in which `sts_pull` is high within a fixed window and expects exactly one.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [3:0] {
        CMD_NOP        = 4'd0,
        CMD_ERASE_BLK  = 4'd1,
        CMD_ERASE_CHIP = 4'd2,
        CMD_WRITE      = 4'd3,
        CMD_LOCK_SET   = 4'd4,
        CMD_LOCK_CLR   = 4'd5,
        CMD_SUSPEND    = 4'd6,
        CMD_RESUME     = 4'd7,
        CMD_CLR_STAT   = 4'd8,
        CMD_CONFIG     = 4'd9
    } cmd_e;

    typedef enum logic [1:0] {
        STS_LEVEL     = 2'd0,
        STS_PULSE_ERS = 2'd1,
        STS_PULSE_WR  = 2'd2,
        STS_PULSE_ANY = 2'd3
    } sts_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ERASE,
        ST_WRITE,
        ST_LOCK,
        ST_ESUSP,
        ST_WSUSP,
        ST_ESWRITE
    } seq_state_e;

    localparam int SB_READY   = 7;
    localparam int SB_ESUSP   = 6;
    localparam int SB_ERS_ERR = 5;
    localparam int SB_WR_ERR  = 4;
    localparam int SB_VPP_ERR = 3;
    localparam int SB_WSUSP   = 2;
    localparam int SB_LK_ERR  = 1;

endpackage

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (start) cnt_q <= '0;
        else if (run)   cnt_q <= cnt_q + 1'b1;
    end

    assign done = run && (cnt_q == limit - 1'b1);
endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
    parameter int NUM_BLK = 32,
    parameter int WPB     = 4,
    parameter int DW      = 8,
    localparam int BW     = $clog2(NUM_BLK),
    localparam int OW     = $clog2(WPB),
    localparam int AW     = BW + OW
) (
    input  logic               clk,
    input  logic               ers_blk_en,
    input  logic               ers_all_en,
    input  logic [BW-1:0]      ers_blk,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic               lk_set_en,
    input  logic [BW-1:0]      lk_blk,
    input  logic               lk_clr_en,
    input  logic [AW-1:0]      rd_addr,
    output logic [DW-1:0]      rd_data,
    output logic [NUM_BLK-1:0] lock_q
);
    logic [DW-1:0] blk_rd [NUM_BLK];

    for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
        logic [DW-1:0] words [WPB];

        always_ff @(posedge clk) begin
            for (int w = 0; w < WPB; w++) begin
                if (ers_all_en || (ers_blk_en && ers_blk == BW'(b)))
                    words[w] <= '1;
                else if (wr_en && wr_addr == AW'(b * WPB + w))
                    words[w] <= words[w] & wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (lk_clr_en)                            lock_q[b] <= 1'b0;
            else if (lk_set_en && lk_blk == BW'(b))   lock_q[b] <= 1'b1;
        end

        assign blk_rd[b] = words[rd_addr[OW-1:0]];
    end

    assign rd_data = blk_rd[rd_addr[AW-1:OW]];
endmodule

// File: rtl/flash_sts_drv.sv
module flash_sts_drv
    import flash_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  sts_mode_e mode,
    input  logic      busy,
    input  logic      ers_evt,
    input  logic      wr_evt,
    output logic      sts_pull
);
    logic pulse_q;

    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else pulse_q <= (ers_evt && (mode == STS_PULSE_ERS || mode == STS_PULSE_ANY))
                     || (wr_evt  && (mode == STS_PULSE_WR  || mode == STS_PULSE_ANY));
    end

    always_comb sts_pull = (mode == STS_LEVEL) ? busy : pulse_q;

    a_r10_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != STS_LEVEL && sts_pull) |=> !sts_pull);

    a_r10_write_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == STS_PULSE_WR && wr_evt) |=> sts_pull);
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int NUM_BLK   = 32,
    parameter int WPB       = 4,
    parameter int DW        = 8,
    parameter int ERASE_CYC = 64,
    parameter int WRITE_CYC = 8,
    parameter int LOCK_CYC  = 4,
    localparam int BW       = $clog2(NUM_BLK),
    localparam int OW       = $clog2(WPB),
    localparam int AW       = BW + OW,
    localparam int MAXC     = (ERASE_CYC > WRITE_CYC)
                              ? ((ERASE_CYC > LOCK_CYC) ? ERASE_CYC : LOCK_CYC)
                              : ((WRITE_CYC > LOCK_CYC) ? WRITE_CYC : LOCK_CYC),
    localparam int CW       = $clog2(MAXC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [3:0]    cmd_code,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    input  logic          wp_n,
    input  logic          vpp_ok,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [7:0]    status,
    output logic          sts_pull
);
    seq_state_e state_q, state_d;
    sts_mode_e  sts_mode_q;
    logic [BW-1:0] ers_blk_q, lk_blk_q;
    logic          ers_chip_q, lk_set_q;
    logic [AW-1:0] wr_addr_q;
    logic [DW-1:0] wr_data_q;
    logic          ers_err_q, wr_err_q, vpp_err_q, lk_err_q;
    logic [NUM_BLK-1:0] lock_q;

    cmd_e          cmd;
    logic [BW-1:0] cmd_blk;
    logic          blk_locked, any_locked;
    logic          ers_start, wr_start, ers_done, wr_done;
    logic          ld_ers, ld_wr, ld_lk, ld_cfg, clr_stat;
    logic          set_ers, set_wr, set_vpp, set_lk;
    logic          ready, busy;
    logic [CW-1:0] wr_limit;
    logic          arr_ers_blk, arr_ers_all, arr_wr, arr_lk_set, arr_lk_clr;

    assign cmd        = cmd_e'(cmd_code);
    assign cmd_blk    = cmd_addr[AW-1:OW];
    assign blk_locked = lock_q[cmd_blk] && !wp_n;
    assign any_locked = (|lock_q) && !wp_n;
    assign wr_limit   = (state_q == ST_LOCK) ? CW'(LOCK_CYC) : CW'(WRITE_CYC);

    flash_op_timer #(.CW(CW)) ers_tmr_i (
        .clk(clk), .rst_n(rst_n), .start(ers_start),
        .run(state_q == ST_ERASE), .limit(CW'(ERASE_CYC)), .done(ers_done));

    flash_op_timer #(.CW(CW)) wr_tmr_i (
        .clk(clk), .rst_n(rst_n), .start(wr_start),
        .run(state_q == ST_WRITE || state_q == ST_ESWRITE || state_q == ST_LOCK),
        .limit(wr_limit), .done(wr_done));

    always_comb begin
        state_d   = state_q;
        ers_start = 1'b0;  wr_start = 1'b0;
        ld_ers    = 1'b0;  ld_wr    = 1'b0;  ld_lk = 1'b0;  ld_cfg = 1'b0;
        clr_stat  = 1'b0;
        set_ers   = 1'b0;  set_wr   = 1'b0;  set_vpp = 1'b0;  set_lk = 1'b0;
        unique case (state_q)
            ST_IDLE: if (cmd_valid) begin
                case (cmd)
                    CMD_ERASE_BLK, CMD_ERASE_CHIP: begin
                        if (!vpp_ok) begin
                            set_vpp = 1'b1; set_ers = 1'b1;
                        end else if ((cmd == CMD_ERASE_BLK) ? blk_locked : any_locked) begin
                            set_lk = 1'b1; set_ers = 1'b1;
                        end else begin
                            ld_ers = 1'b1; ers_start = 1'b1; state_d = ST_ERASE;
                        end
                    end
                    CMD_WRITE: begin
                        if (!vpp_ok) begin
                            set_vpp = 1'b1; set_wr = 1'b1;
                        end else if (blk_locked) begin
                            set_lk = 1'b1; set_wr = 1'b1;
                        end else begin
                            ld_wr = 1'b1; wr_start = 1'b1; state_d = ST_WRITE;
                        end
                    end
                    CMD_LOCK_SET, CMD_LOCK_CLR: begin
                        if (!vpp_ok || !wp_n) begin
                            set_vpp = !vpp_ok; set_lk = !wp_n; set_wr = 1'b1;
                        end else begin
                            ld_lk = 1'b1; wr_start = 1'b1; state_d = ST_LOCK;
                        end
                    end
                    CMD_CLR_STAT: clr_stat = 1'b1;
                    CMD_CONFIG:   ld_cfg   = 1'b1;
                    default: ;
                endcase
            end
            ST_ERASE: begin
                if (ers_done)                                state_d = ST_IDLE;
                else if (cmd_valid && cmd == CMD_SUSPEND)    state_d = ST_ESUSP;
            end
            ST_WRITE: begin
                if (wr_done)                                 state_d = ST_IDLE;
                else if (cmd_valid && cmd == CMD_SUSPEND)    state_d = ST_WSUSP;
            end
            ST_LOCK: if (wr_done) state_d = ST_IDLE;
            ST_ESUSP: if (cmd_valid) begin
                case (cmd)
                    CMD_RESUME:   state_d  = ST_ERASE;
                    CMD_CLR_STAT: clr_stat = 1'b1;
                    CMD_WRITE: begin
                        if (!vpp_ok) begin
                            set_vpp = 1'b1; set_wr = 1'b1;
                        end else if (ers_chip_q || cmd_blk == ers_blk_q) begin
                            set_wr = 1'b1;
                        end else if (blk_locked) begin
                            set_lk = 1'b1; set_wr = 1'b1;
                        end else begin
                            ld_wr = 1'b1; wr_start = 1'b1; state_d = ST_ESWRITE;
                        end
                    end
                    default: ;
                endcase
            end
            ST_WSUSP: if (cmd_valid) begin
                if (cmd == CMD_RESUME)        state_d  = ST_WRITE;
                else if (cmd == CMD_CLR_STAT) clr_stat = 1'b1;
            end
            ST_ESWRITE: if (wr_done) state_d = ST_ESUSP;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            sts_mode_q <= STS_LEVEL;
            ers_blk_q  <= '0;  ers_chip_q <= 1'b0;
            lk_blk_q   <= '0;  lk_set_q   <= 1'b0;
            wr_addr_q  <= '0;  wr_data_q  <= '0;
            ers_err_q  <= 1'b0; wr_err_q <= 1'b0; vpp_err_q <= 1'b0; lk_err_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ld_ers) begin
                ers_blk_q  <= cmd_blk;
                ers_chip_q <= (cmd == CMD_ERASE_CHIP);
            end
            if (ld_wr) begin
                wr_addr_q <= cmd_addr;
                wr_data_q <= cmd_data;
            end
            if (ld_lk) begin
                lk_blk_q <= cmd_blk;
                lk_set_q <= (cmd == CMD_LOCK_SET);
            end
            if (ld_cfg) sts_mode_q <= sts_mode_e'(cmd_data[1:0]);
            if (clr_stat) begin
                ers_err_q <= 1'b0; wr_err_q <= 1'b0; vpp_err_q <= 1'b0; lk_err_q <= 1'b0;
            end else begin
                ers_err_q <= ers_err_q | set_ers;
                wr_err_q  <= wr_err_q  | set_wr;
                vpp_err_q <= vpp_err_q | set_vpp;
                lk_err_q  <= lk_err_q  | set_lk;
            end
        end
    end

    always_comb begin
        ready       = (state_q == ST_IDLE) || (state_q == ST_ESUSP) || (state_q == ST_WSUSP);
        busy        = !ready;
        arr_ers_blk = (state_q == ST_ERASE) && ers_done && !ers_chip_q;
        arr_ers_all = (state_q == ST_ERASE) && ers_done && ers_chip_q;
        arr_wr      = (state_q == ST_WRITE || state_q == ST_ESWRITE) && wr_done;
        arr_lk_set  = (state_q == ST_LOCK) && wr_done && lk_set_q;
        arr_lk_clr  = (state_q == ST_LOCK) && wr_done && !lk_set_q;
        status             = '0;
        status[SB_READY]   = ready;
        status[SB_ESUSP]   = (state_q == ST_ESUSP) || (state_q == ST_ESWRITE);
        status[SB_ERS_ERR] = ers_err_q;
        status[SB_WR_ERR]  = wr_err_q;
        status[SB_VPP_ERR] = vpp_err_q;
        status[SB_WSUSP]   = (state_q == ST_WSUSP);
        status[SB_LK_ERR]  = lk_err_q;
    end

    flash_cell_array #(.NUM_BLK(NUM_BLK), .WPB(WPB), .DW(DW)) arr_i (
        .clk(clk), .ers_blk_en(arr_ers_blk), .ers_all_en(arr_ers_all), .ers_blk(ers_blk_q),
        .wr_en(arr_wr), .wr_addr(wr_addr_q), .wr_data(wr_data_q),
        .lk_set_en(arr_lk_set), .lk_blk(lk_blk_q), .lk_clr_en(arr_lk_clr),
        .rd_addr(rd_addr), .rd_data(rd_data), .lock_q(lock_q));

    flash_sts_drv sts_i (
        .clk(clk), .rst_n(rst_n), .mode(sts_mode_q), .busy(busy),
        .ers_evt(arr_ers_blk || arr_ers_all), .wr_evt(arr_wr), .sts_pull(sts_pull));

    a_r1_erase_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_ers_blk && rd_addr[AW-1:OW] == ers_blk_q) |=> ($stable(rd_addr) -> rd_data == '1));

    a_r3_write_and: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr && rd_addr == wr_addr_q)
        |=> ($stable(rd_addr) -> rd_data == ($past(rd_data) & $past(wr_data_q))));

    a_r4_locked_write_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cmd_valid && cmd_code == CMD_WRITE && vpp_ok && !wp_n && lock_q[cmd_blk])
        |=> (state_q == ST_IDLE && status[SB_LK_ERR]));

    a_r6_no_supply_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cmd_valid && !vpp_ok &&
         cmd_code inside {CMD_ERASE_BLK, CMD_ERASE_CHIP, CMD_WRITE, CMD_LOCK_SET, CMD_LOCK_CLR})
        |=> (state_q == ST_IDLE && status[SB_VPP_ERR]));

    a_r9_level_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_mode_q == STS_LEVEL && !status[SB_READY]) |-> sts_pull);

    a_r11_done_beats_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE && wr_done) |=> !status[SB_WSUSP]);
endmodule

// File: tb/flash_seq_ctrl_tb_top.sv
module flash_seq_ctrl_tb_top;
    import flash_seq_pkg::*;

    localparam int AW = 7;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cmd_valid;
    logic [3:0]    cmd_code;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_data;
    logic          wp_n, vpp_ok;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    logic [7:0]    status;
    logic          sts_pull;

    always #10 clk = ~clk;

    flash_seq_ctrl #(.NUM_BLK(32), .WPB(4), .DW(DW),
                     .ERASE_CYC(6), .WRITE_CYC(3), .LOCK_CYC(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wp_n(wp_n), .vpp_ok(vpp_ok),
        .rd_addr(rd_addr), .rd_data(rd_data), .status(status), .sts_pull(sts_pull));

    int n_chk = 0;
    int n_err = 0;

    typedef struct {
        string         req;
        logic [AW-1:0] addr;
        logic [7:0]    exp;
        bit            is_stat;
    } item_t;

    item_t sb_q[$];
    int    pending = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_rd(string req, logic [AW-1:0] a, logic [7:0] e);
        item_t it;
        it.req = req; it.addr = a; it.exp = e; it.is_stat = 1'b0;
        pending++;
        sb_q.push_back(it);
        wait (pending == 0);
    endtask

    task automatic expect_st(string req, logic [7:0] e);
        item_t it;
        it.req = req; it.addr = '0; it.exp = e; it.is_stat = 1'b1;
        pending++;
        sb_q.push_back(it);
        wait (pending == 0);
    endtask

    initial begin : monitor
        item_t it;
        rd_addr = '0;
        forever begin
            wait (sb_q.size() > 0);
            it = sb_q.pop_front();
            if (!it.is_stat) rd_addr = it.addr;
            @(negedge clk);
            chk(it.req, it.is_stat ? {24'b0, status} : {24'b0, rd_data}, {24'b0, it.exp});
            pending--;
        end
    end

    task automatic issue(cmd_e c, logic [AW-1:0] a, logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = c; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_code = CMD_NOP;
    endtask

    task automatic wait_ready();
        do @(negedge clk); while (!status[7]);
    endtask

    task automatic count_pulses(output int c);
        c = 0;
        repeat (20) begin
            @(negedge clk);
            if (sts_pull) c++;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin : driver
        int pc;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_code = CMD_NOP; cmd_addr = '0; cmd_data = '0;
        wp_n = 1'b1; vpp_ok = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        expect_st("R13 status after reset", 8'h80);
        chk("R13 pin released after reset", sts_pull, 0);

        issue(CMD_LOCK_CLR, 0, 0);
        wait_ready();
        issue(CMD_ERASE_CHIP, 0, 0);
        chk("R9 level pin low while busy", sts_pull, 1);
        wait_ready();
        chk("R9 level pin released when ready", sts_pull, 0);
        expect_rd("R2 chip erase first word", 7'd0, 8'hFF);
        expect_rd("R2 chip erase last word", 7'd127, 8'hFF);
        expect_st("R2 status clean", 8'h80);

        issue(CMD_WRITE, 7'd5, 8'hA5); wait_ready();
        expect_rd("R3 first write", 7'd5, 8'hA5);
        issue(CMD_WRITE, 7'd5, 8'h3C); wait_ready();
        expect_rd("R3 write ANDs", 7'd5, 8'h24);
        issue(CMD_WRITE, 7'd9, 8'h55); wait_ready();
        issue(CMD_ERASE_BLK, 7'd4, 0); wait_ready();
        expect_rd("R1 target block erased", 7'd5, 8'hFF);
        expect_rd("R1 neighbour block kept", 7'd9, 8'h55);

        issue(CMD_LOCK_SET, 7'd12, 0); wait_ready();
        wp_n = 1'b0;
        issue(CMD_WRITE, 7'd12, 8'h00); wait_ready();
        expect_st("R4 locked write rejected", 8'h92);
        expect_rd("R4 locked word unchanged", 7'd12, 8'hFF);
        issue(CMD_CLR_STAT, 0, 0);
        expect_st("R12 clear status", 8'h80);
        wp_n = 1'b1;
        issue(CMD_WRITE, 7'd12, 8'h0F); wait_ready();
        expect_rd("R4 wp high overrides lock", 7'd12, 8'h0F);
        wp_n = 1'b0;
        issue(CMD_LOCK_CLR, 0, 0); wait_ready();
        expect_st("R5 lock clear rejected", 8'h92);
        issue(CMD_CLR_STAT, 0, 0);
        issue(CMD_ERASE_BLK, 7'd12, 0); wait_ready();
        expect_st("R5 lock kept, erase rejected R4", 8'hA2);
        issue(CMD_ERASE_CHIP, 0, 0); wait_ready();
        expect_st("R12 errors stay set", 8'hA2);
        issue(CMD_CLR_STAT, 0, 0);
        wp_n = 1'b1;
        issue(CMD_LOCK_CLR, 0, 0); wait_ready();
        wp_n = 1'b0;
        issue(CMD_ERASE_BLK, 7'd12, 0); wait_ready();
        expect_rd("R5 cleared lock allows erase", 7'd12, 8'hFF);
        wp_n = 1'b1;

        vpp_ok = 1'b0;
        issue(CMD_WRITE, 7'd0, 8'h00); wait_ready();
        expect_st("R6 write without supply", 8'h98);
        expect_rd("R6 word unchanged", 7'd0, 8'hFF);
        issue(CMD_CLR_STAT, 0, 0);
        issue(CMD_ERASE_BLK, 7'd9, 0); wait_ready();
        expect_st("R6 erase without supply", 8'hA8);
        issue(CMD_CLR_STAT, 0, 0);
        vpp_ok = 1'b1;

        issue(CMD_WRITE, 7'd1, 8'h11); wait_ready();
        issue(CMD_ERASE_BLK, 7'd0, 0);
        issue(CMD_SUSPEND, 0, 0);
        expect_st("R7 erase suspended", 8'hC0);
        chk("R7 pin released while suspended", sts_pull, 0);
        expect_rd("R7 data held while suspended", 7'd1, 8'h11);
        issue(CMD_WRITE, 7'd20, 8'h77); wait_ready();
        expect_rd("R7 write to other block", 7'd20, 8'h77);
        issue(CMD_WRITE, 7'd2, 8'h00); wait_ready();
        expect_st("R7 same-block write rejected", 8'hD0);
        issue(CMD_CLR_STAT, 0, 0);
        expect_st("R12 clear keeps suspend bit", 8'hC0);
        issue(CMD_RESUME, 0, 0); wait_ready();
        expect_st("R7 resumed erase done", 8'h80);
        expect_rd("R7 erase completed", 7'd1, 8'hFF);

        issue(CMD_WRITE, 7'd30, 8'h0F);
        issue(CMD_SUSPEND, 0, 0);
        expect_st("R8 write suspended", 8'h84);
        issue(CMD_RESUME, 0, 0); wait_ready();
        expect_rd("R8 resumed write done", 7'd30, 8'h0F);

        issue(CMD_CONFIG, 0, 8'd1);
        issue(CMD_ERASE_BLK, 7'd28, 0); count_pulses(pc);
        chk("R10 erase pulse mode, erase", pc, 1);
        issue(CMD_WRITE, 7'd28, 8'hF0); count_pulses(pc);
        chk("R10 erase pulse mode, write", pc, 0);
        issue(CMD_CONFIG, 0, 8'd2);
        issue(CMD_WRITE, 7'd29, 8'hF0); count_pulses(pc);
        chk("R10 write pulse mode, write", pc, 1);
        issue(CMD_ERASE_BLK, 7'd24, 0); count_pulses(pc);
        chk("R10 write pulse mode, erase", pc, 0);
        issue(CMD_CONFIG, 0, 8'd3);
        issue(CMD_ERASE_BLK, 7'd24, 0); count_pulses(pc);
        chk("R10 both mode, erase", pc, 1);
        issue(CMD_CONFIG, 0, 8'd0);

        issue(CMD_WRITE, 7'd33, 8'h5A);
        @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = CMD_SUSPEND;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_code = CMD_NOP;
        expect_st("R11 suspend on final cycle ignored", 8'h80);
        expect_rd("R11 write completed", 7'd33, 8'h5A);
        issue(CMD_WRITE, 7'd34, 8'h5A);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = CMD_SUSPEND;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_code = CMD_NOP;
        expect_st("R11 earlier suspend honoured", 8'h84);
        issue(CMD_RESUME, 0, 0); wait_ready();

        issue(CMD_WRITE, 7'd40, 8'h3C); wait_ready();
        issue(CMD_CONFIG, 0, 8'd1);
        vpp_ok = 1'b0;
        issue(CMD_WRITE, 7'd41, 8'h00);
        vpp_ok = 1'b1;
        issue(CMD_ERASE_BLK, 7'd40, 0);
        @(negedge clk);
        rst_n = 1'b0;
        chk("R13 pin released in reset", sts_pull, 0);
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        expect_st("R13 status after reset mid-erase", 8'h80);
        expect_rd("R13 aborted erase left data", 7'd40, 8'h3C);
        issue(CMD_WRITE, 7'd41, 8'hAA);
        chk("R13 level mode after reset", sts_pull, 1);
        wait_ready();

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule